// File: doc/BRIEF.md
# Buffer Descriptor DMA Chunk Sequencer

This block walks one audio stream's DMA through a list of buffer descriptors held in system memory. A fetch command loads one 16-byte descriptor from the list into the block. The descriptor gives a buffer address, a byte size and a flag that asks for an interrupt once the buffer has been used up. A transfer command then moves a requested number of bytes between that buffer and memory. The block issues bursts no longer than the stream FIFO, starts at the current position inside the buffer, and never runs past the buffer's end.

Software or a stream engine drives the two commands. It reads back the completion and interrupt-request levels to decide when to fetch the next entry. Memory sits behind a plain request/acknowledge port that carries an error flag. The sample data itself is not part of this block; a burst is described only by its address, length and direction.

Top module: `bdl_dma_seq`

## Requirements
- R1: After reset no memory request or done pulse is active, the current index and offset are zero, and the completion and interrupt-request outputs are low.
- R2: A fetch whose list base is zero makes no memory request. In the cycle after the command, fetch_done_o and fetch_err_o pulse together, and the loaded descriptor is left unchanged.
- R3: A fetch with a non-zero base issues two 8-byte reads, at base + index*16 and at base + index*16 + 8. The first word is the buffer address. In the second word, bits 31:0 are the byte size and bit 32 is the interrupt-on-completion flag. Success loads these values, sets the offset to zero and stores the index.
- R4: A transfer moves min(requested bytes, size - offset) bytes.
- R5: Each burst moves min(bytes still to move, FIFO size) bytes. A FIFO size of zero counts as one byte.
- R6: The first burst address is buffer address + offset, and each later burst starts where the previous one ended. mem_we_o equals the transfer direction, 1 meaning the block writes memory.
- R7: The offset grows by each completed burst. The transfer ends with one xfer_done_o pulse whose xfer_count_o is the total moved. A transfer with nothing to move pulses done, with count 0, in the cycle after the command and makes no request.
- R8: desc_complete_o is high when a descriptor is loaded and either its size is zero or its offset has reached its size.
- R9: irq_req_o is high exactly when desc_complete_o is high and the loaded interrupt-on-completion flag is set.
- R10: A memory error ends the operation after the failing burst. A transfer reports xfer_err_o with a count of 0. A fetch reports fetch_err_o and keeps the previous descriptor.
- R11: Fetch and transfer commands that arrive while busy_o is high are ignored.
- R12: A memory request holds its address, length and direction unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_i | input | 1 | Fetch command pulse |
| list_base_i | input | 64 | Descriptor list base address |
| entry_idx_i | input | IDX_W | Descriptor index to fetch |
| xfer_i | input | 1 | Transfer command pulse |
| xfer_bytes_i | input | 32 | Requested byte count |
| xfer_dir_i | input | 1 | 1 = write memory, 0 = read memory |
| fifo_size_i | input | FIFO_W | Stream FIFO size in bytes |
| busy_o | output | 1 | Operation in progress |
| fetch_done_o | output | 1 | Fetch finished pulse |
| fetch_err_o | output | 1 | Fetch failed, valid with fetch_done_o |
| xfer_done_o | output | 1 | Transfer finished pulse |
| xfer_err_o | output | 1 | Transfer failed, valid with xfer_done_o |
| xfer_count_o | output | 32 | Bytes moved, valid with xfer_done_o |
| cur_idx_o | output | IDX_W | Index of loaded descriptor |
| cur_off_o | output | 32 | Byte offset inside current buffer |
| desc_complete_o | output | 1 | Current buffer used up |
| irq_req_o | output | 1 | Completion interrupt requested |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request writes memory |
| mem_addr_o | output | 64 | Request byte address |
| mem_len_o | output | FIFO_W | Request byte length |
| mem_ack_i | input | 1 | Request acknowledged |
| mem_err_i | input | 1 | Request failed, valid with mem_ack_i |
| mem_rdata_i | input | 64 | Read data, valid with mem_ack_i |

## Verification
The hardest case to reach is a memory error in the middle of a multi-burst transfer. The bench arms its memory model to fail at one chosen burst address in the middle of a buffer. It then checks that the earlier bursts still advanced the offset and that no burst follows the failing one. A follow-up transfer then has to start exactly at the surviving offset. A second awkward case is a command that arrives during a long run of one-FIFO bursts. The bench injects one mid-run and relies on the burst scoreboard, and on the unchanged index afterwards, to show that it was dropped.

// File: rtl/bdl_seq_pkg.sv
package bdl_seq_pkg;
  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned SIZE_W     = 32;
  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned DESC_BYTES = 16;
  localparam int unsigned DESC_SHIFT = $clog2(DESC_BYTES);
  localparam int unsigned IOC_BIT    = 32;  // position in second descriptor word

  typedef struct packed {
    logic [ADDR_W-1:0] buf_addr;
    logic [SIZE_W-1:0] size;
    logic              ioc;
  } desc_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DESC_LO,
    ST_DESC_HI,
    ST_MOVE
  } seq_state_e;
endpackage

// File: rtl/bdl_chunk_calc.sv
module bdl_chunk_calc
  import bdl_seq_pkg::*;
#(
  parameter int unsigned FIFO_W = 16
) (
  input  logic [SIZE_W-1:0] rem_i,
  input  logic [FIFO_W-1:0] fifo_i,
  output logic [SIZE_W-1:0] chunk_o
);
  logic [SIZE_W-1:0] fifo_eff;

  always_comb begin
    fifo_eff = SIZE_W'(fifo_i);
    if (fifo_i == '0) fifo_eff = SIZE_W'(1);
    chunk_o = (rem_i < fifo_eff) ? rem_i : fifo_eff;
  end
endmodule

// File: rtl/bdl_desc_store.sv
module bdl_desc_store
  import bdl_seq_pkg::*;
#(
  parameter int unsigned IDX_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  desc_t             load_desc_i,
  input  logic [IDX_W-1:0]  load_idx_i,
  input  logic              adv_i,
  input  logic [SIZE_W-1:0] adv_bytes_i,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [SIZE_W-1:0] off_o,
  output logic [SIZE_W-1:0] avail_o,
  output logic              complete_o,
  output logic              irq_o
);
  desc_t             desc_q;
  logic              valid_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SIZE_W-1:0] off_q;
  logic              used_up;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_q  <= '0;
      valid_q <= 1'b0;
      idx_q   <= '0;
      off_q   <= '0;
    end else if (load_i) begin
      desc_q  <= load_desc_i;
      valid_q <= 1'b1;
      idx_q   <= load_idx_i;
      off_q   <= '0;
    end else if (adv_i) begin
      off_q <= off_q + adv_bytes_i;
    end
  end

  assign used_up    = (desc_q.size == '0) || (off_q >= desc_q.size);
  assign avail_o    = used_up ? '0 : (desc_q.size - off_q);
  assign complete_o = valid_q && used_up;
  assign irq_o      = complete_o && desc_q.ioc;
  assign buf_addr_o = desc_q.buf_addr;
  assign idx_o      = idx_q;
  assign off_o      = off_q;

  // R7: clipping keeps the offset inside the buffer
  a_r7_off_in_buffer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (off_q <= desc_q.size));

  // R3: a load restarts the buffer at offset zero
  a_r3_load_clears_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (off_q == '0) && valid_q);

  // R7: advance never moves past the available space
  a_r7_adv_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (adv_bytes_i <= avail_o) && (adv_bytes_i != '0));
endmodule

// File: rtl/bdl_seq_ctrl.sv
module bdl_seq_ctrl
  import bdl_seq_pkg::*;
#(
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned FIFO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] list_base_i,
  input  logic [IDX_W-1:0]  entry_idx_i,
  input  logic              xfer_i,
  input  logic [SIZE_W-1:0] xfer_bytes_i,
  input  logic              xfer_dir_i,
  input  logic [FIFO_W-1:0] fifo_size_i,
  input  logic [ADDR_W-1:0] buf_addr_i,
  input  logic [SIZE_W-1:0] off_i,
  input  logic [SIZE_W-1:0] avail_i,
  output logic              load_o,
  output desc_t             load_desc_o,
  output logic [IDX_W-1:0]  load_idx_o,
  output logic              adv_o,
  output logic [SIZE_W-1:0] adv_bytes_o,
  output logic              busy_o,
  output logic              fetch_done_o,
  output logic              fetch_err_o,
  output logic              xfer_done_o,
  output logic              xfer_err_o,
  output logic [SIZE_W-1:0] xfer_count_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [FIFO_W-1:0] mem_len_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [63:0]       mem_rdata_i
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [ADDR_W-1:0] lo_word_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SIZE_W-1:0] rem_q;
  logic [SIZE_W-1:0] total_q;
  logic [FIFO_W-1:0] fifo_q;
  logic              dir_q;
  logic [SIZE_W-1:0] chunk;
  logic [SIZE_W-1:0] start_bytes;
  logic [ADDR_W-1:0] desc_addr;

  bdl_chunk_calc #(.FIFO_W(FIFO_W)) i_chunk (
    .rem_i  (rem_q),
    .fifo_i (fifo_q),
    .chunk_o(chunk)
  );

  assign start_bytes = (xfer_bytes_i < avail_i) ? xfer_bytes_i : avail_i;
  assign desc_addr   = list_base_i + (ADDR_W'(entry_idx_i) << DESC_SHIFT);

  always_comb begin
    mem_req_o  = (state_q != ST_IDLE);
    mem_we_o   = (state_q == ST_MOVE) && dir_q;
    mem_len_o  = FIFO_W'(WORD_BYTES);
    mem_addr_o = rd_addr_q;
    if (state_q == ST_MOVE) begin
      mem_addr_o = buf_addr_i + ADDR_W'(off_i);
      mem_len_o  = chunk[FIFO_W-1:0];
    end else if (state_q == ST_DESC_HI) begin
      mem_addr_o = rd_addr_q + ADDR_W'(WORD_BYTES);
    end
  end

  assign load_o      = (state_q == ST_DESC_HI) && mem_ack_i && !mem_err_i;
  assign load_desc_o = '{buf_addr: lo_word_q,
                         size:     mem_rdata_i[SIZE_W-1:0],
                         ioc:      mem_rdata_i[IOC_BIT]};
  assign load_idx_o  = idx_q;
  assign adv_o       = (state_q == ST_MOVE) && mem_ack_i && !mem_err_i;
  assign adv_bytes_o = chunk;
  assign busy_o      = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      rd_addr_q    <= '0;
      lo_word_q    <= '0;
      idx_q        <= '0;
      rem_q        <= '0;
      total_q      <= '0;
      fifo_q       <= '0;
      dir_q        <= 1'b0;
      fetch_done_o <= 1'b0;
      fetch_err_o  <= 1'b0;
      xfer_done_o  <= 1'b0;
      xfer_err_o   <= 1'b0;
      xfer_count_o <= '0;
    end else begin
      fetch_done_o <= 1'b0;
      fetch_err_o  <= 1'b0;
      xfer_done_o  <= 1'b0;
      xfer_err_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fetch_i) begin
            if (list_base_i == '0) begin
              fetch_done_o <= 1'b1;
              fetch_err_o  <= 1'b1;
            end else begin
              rd_addr_q <= desc_addr;
              idx_q     <= entry_idx_i;
              state_q   <= ST_DESC_LO;
            end
          end else if (xfer_i) begin
            if (start_bytes == '0) begin
              xfer_done_o  <= 1'b1;
              xfer_count_o <= '0;
            end else begin
              rem_q   <= start_bytes;
              total_q <= '0;
              fifo_q  <= fifo_size_i;
              dir_q   <= xfer_dir_i;
              state_q <= ST_MOVE;
            end
          end
        end
        ST_DESC_LO: begin
          if (mem_ack_i) begin
            if (mem_err_i) begin
              fetch_done_o <= 1'b1;
              fetch_err_o  <= 1'b1;
              state_q      <= ST_IDLE;
            end else begin
              lo_word_q <= mem_rdata_i;
              state_q   <= ST_DESC_HI;
            end
          end
        end
        ST_DESC_HI: begin
          if (mem_ack_i) begin
            fetch_done_o <= 1'b1;
            fetch_err_o  <= mem_err_i;
            state_q      <= ST_IDLE;
          end
        end
        ST_MOVE: begin
          if (mem_ack_i) begin
            if (mem_err_i) begin
              xfer_done_o  <= 1'b1;
              xfer_err_o   <= 1'b1;
              xfer_count_o <= '0;
              state_q      <= ST_IDLE;
            end else begin
              total_q <= total_q + chunk;
              rem_q   <= rem_q - chunk;
              if (rem_q == chunk) begin
                xfer_done_o  <= 1'b1;
                xfer_count_o <= total_q + chunk;
                state_q      <= ST_IDLE;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R12: request fields hold until acknowledged
  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o)
                                  && $stable(mem_len_o) && $stable(mem_we_o));

  // R5: burst length bounded by the FIFO, never empty
  a_r5_burst_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MOVE) |-> (mem_len_o != '0) &&
                             ((fifo_q == '0) ? (mem_len_o == FIFO_W'(1)) : (mem_len_o <= fifo_q)));

  // R2: zero list base never reaches memory
  a_r2_zero_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && fetch_i && (list_base_i == '0)) |=> !mem_req_o && fetch_done_o && fetch_err_o);

  // R10: an error response ends the operation
  a_r10_err_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && mem_err_i) |=> !mem_req_o);

  // R10: a failed transfer carries no byte count
  a_r10_err_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_o && xfer_err_o) |-> (xfer_count_o == '0));

  // R7: done pulses only when the sequencer has returned to idle
  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_o || fetch_done_o) |-> !mem_req_o);
endmodule

// File: rtl/bdl_dma_seq.sv
module bdl_dma_seq
  import bdl_seq_pkg::*;
#(
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned FIFO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic [63:0]       list_base_i,
  input  logic [IDX_W-1:0]  entry_idx_i,
  input  logic              xfer_i,
  input  logic [31:0]       xfer_bytes_i,
  input  logic              xfer_dir_i,
  input  logic [FIFO_W-1:0] fifo_size_i,
  output logic              busy_o,
  output logic              fetch_done_o,
  output logic              fetch_err_o,
  output logic              xfer_done_o,
  output logic              xfer_err_o,
  output logic [31:0]       xfer_count_o,
  output logic [IDX_W-1:0]  cur_idx_o,
  output logic [31:0]       cur_off_o,
  output logic              desc_complete_o,
  output logic              irq_req_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [63:0]       mem_addr_o,
  output logic [FIFO_W-1:0] mem_len_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [63:0]       mem_rdata_i
);
  logic              load;
  desc_t             load_desc;
  logic [IDX_W-1:0]  load_idx;
  logic              adv;
  logic [SIZE_W-1:0] adv_bytes;
  logic [ADDR_W-1:0] buf_addr;
  logic [SIZE_W-1:0] avail;

  bdl_seq_ctrl #(.IDX_W(IDX_W), .FIFO_W(FIFO_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_i      (fetch_i),
    .list_base_i  (list_base_i),
    .entry_idx_i  (entry_idx_i),
    .xfer_i       (xfer_i),
    .xfer_bytes_i (xfer_bytes_i),
    .xfer_dir_i   (xfer_dir_i),
    .fifo_size_i  (fifo_size_i),
    .buf_addr_i   (buf_addr),
    .off_i        (cur_off_o),
    .avail_i      (avail),
    .load_o       (load),
    .load_desc_o  (load_desc),
    .load_idx_o   (load_idx),
    .adv_o        (adv),
    .adv_bytes_o  (adv_bytes),
    .busy_o       (busy_o),
    .fetch_done_o (fetch_done_o),
    .fetch_err_o  (fetch_err_o),
    .xfer_done_o  (xfer_done_o),
    .xfer_err_o   (xfer_err_o),
    .xfer_count_o (xfer_count_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_len_o    (mem_len_o),
    .mem_ack_i    (mem_ack_i),
    .mem_err_i    (mem_err_i),
    .mem_rdata_i  (mem_rdata_i)
  );

  bdl_desc_store #(.IDX_W(IDX_W)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_desc_i (load_desc),
    .load_idx_i  (load_idx),
    .adv_i       (adv),
    .adv_bytes_i (adv_bytes),
    .buf_addr_o  (buf_addr),
    .idx_o       (cur_idx_o),
    .off_o       (cur_off_o),
    .avail_o     (avail),
    .complete_o  (desc_complete_o),
    .irq_o       (irq_req_o)
  );
endmodule

// File: tb/test_bdl_dma_seq.sv
module test_bdl_dma_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch = 1'b0;
  logic [63:0] list_base = '0;
  logic [15:0] entry_idx = '0;
  logic        xfer = 1'b0;
  logic [31:0] xfer_bytes = '0;
  logic        xfer_dir = 1'b0;
  logic [15:0] fifo_size = 16'd16;
  logic        busy, fetch_done, fetch_err, xfer_done, xfer_err;
  logic [31:0] xfer_count, cur_off;
  logic [15:0] cur_idx;
  logic        complete, irq_req;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [15:0] mem_len;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  bdl_dma_seq i_bdl_dma_seq (
    .clk_i(clk), .rst_ni(rst_n), .fetch_i(fetch), .list_base_i(list_base),
    .entry_idx_i(entry_idx), .xfer_i(xfer), .xfer_bytes_i(xfer_bytes),
    .xfer_dir_i(xfer_dir), .fifo_size_i(fifo_size), .busy_o(busy),
    .fetch_done_o(fetch_done), .fetch_err_o(fetch_err), .xfer_done_o(xfer_done),
    .xfer_err_o(xfer_err), .xfer_count_o(xfer_count), .cur_idx_o(cur_idx),
    .cur_off_o(cur_off), .desc_complete_o(complete), .irq_req_o(irq_req),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_len_o(mem_len), .mem_ack_i(mem_ack), .mem_err_i(mem_err),
    .mem_rdata_i(mem_rdata)
  );

  typedef struct { logic [63:0] addr; logic [15:0] len; bit we; string tag; } burst_t;
  typedef struct { bit is_fetch; bit err; logic [31:0] cnt; string tag; } done_t;

  burst_t      exp_mem[$];
  done_t       exp_done[$];
  logic [63:0] mem_img[logic [63:0]];
  bit          err_en = 1'b0;
  logic [63:0] err_addr = '0;
  int          total = 0;
  int          bad = 0;
  int          wait_cnt = 0;
  int          lat_sel = 0;
  bit          finished = 1'b0;

  // reference model of the loaded descriptor
  bit          m_valid = 1'b0;
  logic [63:0] m_buf = '0;
  logic [31:0] m_size = '0;
  logic [31:0] m_flags = '0;
  logic [31:0] m_off = '0;
  logic [15:0] m_idx = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory model and burst scoreboard monitor
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        if (exp_mem.size() == 0) begin
          chk(1'b0, "R11", "unexpected memory request", mem_addr, 64'h0);
        end else begin
          burst_t e;
          e = exp_mem.pop_front();
          chk(mem_addr == e.addr, e.tag, "burst address", mem_addr, e.addr);
          chk(mem_len == e.len, e.tag, "burst length", 64'(mem_len), 64'(e.len));
          chk(mem_we == e.we, e.tag, "burst direction", 64'(mem_we), 64'(e.we));
        end
        mem_ack   <= 1'b1;
        mem_err   <= err_en && (mem_addr == err_addr);
        mem_rdata <= mem_img.exists(mem_addr) ? mem_img[mem_addr] : 64'h0;
        lat_sel   <= (lat_sel + 1) % 3;
        wait_cnt  <= (lat_sel == 0) ? 2 : (lat_sel == 1) ? 0 : 1;
      end else begin
        wait_cnt <= wait_cnt - 1;
      end
    end
  end

  // completion scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (fetch_done || xfer_done)) begin
      if (exp_done.size() == 0) begin
        chk(1'b0, "R11", "unexpected done pulse", {62'h0, fetch_done, xfer_done}, 64'h0);
      end else begin
        done_t d;
        d = exp_done.pop_front();
        chk(fetch_done == d.is_fetch && xfer_done == !d.is_fetch, d.tag, "done kind",
            {62'h0, fetch_done, xfer_done}, {62'h0, d.is_fetch, !d.is_fetch});
        chk((d.is_fetch ? fetch_err : xfer_err) == d.err, d.tag, "error flag",
            64'(d.is_fetch ? fetch_err : xfer_err), 64'(d.err));
        if (!d.is_fetch)
          chk(xfer_count == d.cnt, d.tag, "byte count", 64'(xfer_count), 64'(d.cnt));
      end
    end
  end

  task automatic put_desc(input logic [63:0] base, input logic [15:0] idx,
                          input logic [63:0] buf_a, input logic [31:0] size,
                          input logic [31:0] flags);
    logic [63:0] a;
    a = base + (64'(idx) << 4);
    mem_img[a]     = buf_a;
    mem_img[a + 8] = {flags, size};
  endtask

  task automatic wait_idle();
    while (exp_done.size() != 0 || exp_mem.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_state(input string tag);
    bit c;
    c = m_valid && ((m_size == 0) || (m_off >= m_size));
    chk(cur_idx == m_idx, tag, "index", 64'(cur_idx), 64'(m_idx));
    chk(cur_off == m_off, tag, "offset", 64'(cur_off), 64'(m_off));
    chk(complete == c, {tag, "/R8"}, "complete level", 64'(complete), 64'(c));
    chk(irq_req == (c && m_flags[0]), {tag, "/R9"}, "irq level", 64'(irq_req), 64'(c && m_flags[0]));
    chk(!mem_req && !busy, tag, "idle after op", {62'h0, mem_req, busy}, 64'h0);
  endtask

  task automatic do_fetch(input logic [63:0] base, input logic [15:0] idx, input string tag);
    logic [63:0] a;
    bit fail;
    done_t d;
    a = base + (64'(idx) << 4);
    fail = 1'b0;
    if (base == 0) begin
      fail = 1'b1;
    end else begin
      exp_mem.push_back('{a, 16'd8, 1'b0, tag});
      if (err_en && a == err_addr) fail = 1'b1;
      else begin
        exp_mem.push_back('{a + 8, 16'd8, 1'b0, tag});
        if (err_en && a + 8 == err_addr) fail = 1'b1;
      end
    end
    d = '{1'b1, fail, 32'h0, tag};
    exp_done.push_back(d);
    if (!fail) begin
      m_valid = 1'b1;
      m_buf   = mem_img[a];
      m_size  = mem_img[a + 8][31:0];
      m_flags = mem_img[a + 8][63:32];
      m_off   = '0;
      m_idx   = idx;
    end
    @(negedge clk);
    list_base = base;
    entry_idx = idx;
    fetch     = 1'b1;
    @(negedge clk);
    fetch = 1'b0;
    if (base == 0)
      chk(fetch_done && fetch_err && !mem_req, "R2", "zero base done next cycle",
          {61'h0, fetch_done, fetch_err, mem_req}, 64'h6);
    wait_idle();
    check_state(tag);
  endtask

  task automatic do_xfer(input logic [31:0] n, input bit dir, input logic [15:0] fifo,
                         input string tag, input bit poke);
    logic [31:0] avail, mv, f, left, c, moved;
    logic [63:0] a;
    bit fail;
    done_t d;
    avail = (m_off >= m_size) ? 32'h0 : m_size - m_off;
    mv    = (n < avail) ? n : avail;
    f     = (fifo == 0) ? 32'd1 : 32'(fifo);
    left  = mv;
    a     = m_buf + 64'(m_off);
    fail  = 1'b0;
    moved = '0;
    while (left != 0 && !fail) begin
      c = (left < f) ? left : f;
      exp_mem.push_back('{a, c[15:0], dir, tag});
      if (err_en && a == err_addr) fail = 1'b1;
      else begin
        a     = a + 64'(c);
        left  = left - c;
        moved = moved + c;
      end
    end
    d = '{1'b0, fail, fail ? 32'h0 : mv, tag};
    exp_done.push_back(d);
    m_off = m_off + moved;
    @(negedge clk);
    xfer_bytes = n;
    xfer_dir   = dir;
    fifo_size  = fifo;
    xfer       = 1'b1;
    @(negedge clk);
    xfer = 1'b0;
    if (mv == 0)
      chk(xfer_done && xfer_count == 0 && !mem_req, "R7", "empty transfer done next cycle",
          {31'h0, xfer_done, xfer_count}, {31'h0, 1'b1, 32'h0});
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy, "R11", "busy during long transfer", 64'(busy), 64'h1);
      list_base = 64'h1000;
      entry_idx = 16'd9;
      fetch     = 1'b1;
      xfer      = 1'b1;
      @(negedge clk);
      fetch = 1'b0;
      xfer  = 1'b0;
    end
    wait_idle();
    check_state(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!mem_req && !fetch_done && !xfer_done, "R1", "no activity in reset",
        {61'h0, mem_req, fetch_done, xfer_done}, 64'h0);
    chk(cur_idx == 0 && cur_off == 0, "R1", "index/offset cleared", 64'(cur_off), 64'h0);
    chk(!complete && !irq_req, "R1", "levels low", {62'h0, complete, irq_req}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    put_desc(64'h1000, 16'd0, 64'h0000_8000_0000_0000, 32'd100, 32'h1);
    put_desc(64'h1000, 16'd3, 64'h0000_0000_4444_0000, 32'd0,   32'h0);
    put_desc(64'h1000, 16'd5, 64'h0000_0000_2000_0001, 32'd50,  32'h0);
    put_desc(64'h1000, 16'd6, 64'h0000_0000_0000_9000, 32'd64,  32'h1);
    put_desc(64'h1000, 16'd7, 64'h0000_0000_0000_7000, 32'd32,  32'h1);
    put_desc(64'h1000, 16'd8, 64'h0000_0000_0000_A000, 32'd200, 32'h0);
    put_desc(64'h1000, 16'd9, 64'h0000_0000_0000_B000, 32'd10,  32'h1);

    do_fetch(64'h1000, 16'd0, "R3");
    do_xfer(32'd40,  1'b0, 16'd16, "R5", 1'b0);   // 16,16,8
    do_xfer(32'd100, 1'b1, 16'd32, "R4", 1'b0);   // clipped to 60: 32,28
    do_xfer(32'd10,  1'b0, 16'd16, "R7", 1'b0);   // nothing left

    do_fetch(64'h1000, 16'd3, "R8");              // zero-length descriptor
    do_xfer(32'd5, 1'b0, 16'd16, "R8", 1'b0);

    do_fetch(64'h0, 16'd4, "R2");                 // zero base, descriptor kept

    do_fetch(64'h1000, 16'd5, "R6");
    do_xfer(32'd3,  1'b1, 16'd0,  "R5", 1'b0);    // FIFO 0 acts as 1
    do_xfer(32'd47, 1'b0, 16'd64, "R6", 1'b0);    // completes, no irq flag

    do_fetch(64'h1000, 16'd6, "R10");
    err_en   = 1'b1;
    err_addr = 64'h9010;
    do_xfer(32'd64, 1'b0, 16'd16, "R10", 1'b0);   // error on second burst
    err_en = 1'b0;
    do_xfer(32'd64, 1'b1, 16'd16, "R6", 1'b0);    // resumes at offset 16

    err_en   = 1'b1;
    err_addr = 64'h1000 + (64'd7 << 4) + 8;
    do_fetch(64'h1000, 16'd7, "R10");             // fetch error keeps old
    err_en = 1'b0;

    do_fetch(64'h1000, 16'd8, "R11");
    do_xfer(32'd200, 1'b0, 16'd8, "R11", 1'b1);   // commands during busy
    chk(cur_idx == 16'd8, "R11", "index untouched by ignored fetch", 64'(cur_idx), 64'd8);

    repeat (5) @(negedge clk);
    chk(exp_mem.size() == 0 && exp_done.size() == 0, "R12", "scoreboard drained",
        64'(exp_mem.size() + exp_done.size()), 64'h0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R12 watchdog expired: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule